// File: doc/BRIEF.md
# Vector Memory Address Generator

This block produces the sequence of byte addresses that a single vector load or store instruction touches. A command carries a base address, an addressing mode, a byte stride, an element width code and an element count. Once the command is accepted, the block emits one address per element over a valid/ready channel toward an interleaved multi-bank memory. Each address carries the element number it belongs to and the number of the bank it falls in.

Three addressing patterns are supported. Contiguous mode steps by the element size. Strided mode adds a signed byte stride after each element. Indexed (gather/scatter) mode takes one element index per address from a separate valid/ready stream and scales it by the element size. The block raises a one-cycle completion pulse once the final address has been taken, and then becomes ready for the next command. The memory banks, the data path and the register file are outside this block.

Top module: `vec_addr_gen`

## Requirements
- R1: A command is taken on a clock edge where `cmd_start` and `cmd_ready` are both high. For a nonzero count, `cmd_ready` is low in the following cycle and stays low until the completion pulse.
- R2: In contiguous mode (`cmd_mode` = 0), element k has address base + k*S. S is 1, 2, 4 or 8 bytes for `cmd_ewidth` codes 0, 1, 2 and 3. Mode code 3 behaves as contiguous.
- R3: In strided mode (`cmd_mode` = 1), element k has address base + k*stride. The stride is a two's complement byte count, and the sum wraps modulo 2^AW.
- R4: In indexed mode (`cmd_mode` = 2), element k has address base + idx_k*S, where idx_k is the k-th unsigned index accepted on the index channel. Exactly one index is consumed per address, and `idx_ready` stays low in the other modes.
- R5: `addr_bank` equals address bits [5:3], the bits just above the 8-byte word offset, for 8 banks.
- R6: `addr_elem` numbers the addresses 0, 1, 2, ... in the order they are emitted.
- R7: Exactly min(`cmd_vlen`, 32) addresses are emitted per command. A count above 32 is treated as 32.
- R8: `done` is high for exactly one cycle, in the cycle right after the edge on which the last address is accepted.
- R9: A count of zero emits no address. It raises `done` in the cycle right after the command is taken, and leaves the block ready.
- R10: While `addr_valid` is high and `addr_ready` is low, the next cycle still shows `addr_valid` high with unchanged address, element and bank. No element is lost.
- R11: During reset, `addr_valid`, `idx_ready` and `done` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_base | input | AW | Base byte address |
| cmd_mode | input | 2 | 0 contiguous, 1 strided, 2 indexed |
| cmd_stride | input | AW | Signed byte stride for strided mode |
| cmd_ewidth | input | 2 | Element width code: 0=8b, 1=16b, 2=32b, 3=64b |
| cmd_vlen | input | VLW | Element count (0..MAX_VL, larger values clamp) |
| idx_valid | input | 1 | Index available |
| idx_ready | output | 1 | Index taken on this edge when valid |
| idx_data | input | IW | Unsigned element index |
| addr_valid | output | 1 | Address available |
| addr_ready | input | 1 | Memory side accepts the address |
| addr_out | output | AW | Byte address |
| addr_elem | output | EW | Element number of the address |
| addr_bank | output | BW | Bank number of the address |
| done | output | 1 | One-cycle completion pulse |

## Verification
After the edge that accepts a command, the first address is valid after the next edge; in indexed mode this also requires an index to be present. Each later address is due one edge after the previous one is accepted, or one edge after its index arrives. `done` is due exactly one edge after the final address handshake, or one edge after a zero-count command is accepted. Inputs change just after rising edges and every output is sampled at the falling edge, so a handshake seen at a falling edge is the one the next rising edge completes. The completion check therefore expects `done` at the falling edge immediately after that one. The hold check compares each stalled address with the value seen one falling edge earlier.

// File: rtl/vag_pkg.sv
package vag_pkg;

    typedef enum logic [1:0] {
        AM_UNIT   = 2'd0,
        AM_STRIDE = 2'd1,
        AM_INDEX  = 2'd2,
        AM_RSVD   = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } ewidth_e;

    typedef struct packed {
        amode_e  mode;
        ewidth_e width;
    } acfg_t;

    // log2 of the element size in bytes
    function automatic logic [1:0] size_shift(input ewidth_e w);
        return logic'(w[1]) ? {1'b1, w[0]} : {1'b0, w[0]};
    endfunction

    function automatic logic is_indexed(input amode_e m);
        return m == AM_INDEX;
    endfunction

endpackage

// File: rtl/vag_step.sv
module vag_step
    import vag_pkg::*;
#(
    parameter int AW = 32
) (
    input  acfg_t          cfg,
    input  logic [AW-1:0]  stride,
    output logic [AW-1:0]  step
);
    always_comb begin
        unique case (cfg.mode)
            AM_STRIDE: step = stride;
            AM_INDEX:  step = '0;
            default:   step = AW'(1) << size_shift(cfg.width);
        endcase
    end
endmodule

// File: rtl/vag_index_scale.sv
module vag_index_scale
    import vag_pkg::*;
#(
    parameter int AW = 32,
    parameter int IW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [IW-1:0] index,
    input  ewidth_e       width,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] scaled;
    always_comb begin
        scaled = AW'(index) << size_shift(width);
        addr   = base + scaled;
    end
endmodule

// File: rtl/vag_bank_sel.sv
module vag_bank_sel #(
    parameter int AW         = 32,
    parameter int NBANK      = 8,
    parameter int WORD_BYTES = 8,
    localparam int BW        = $clog2(NBANK),
    localparam int BANK_LSB  = $clog2(WORD_BYTES)
) (
    input  logic [AW-1:0] addr,
    output logic [BW-1:0] bank
);
    assign bank = addr[BANK_LSB +: BW];
endmodule

// File: rtl/vag_seq.sv
module vag_seq #(
    parameter int MAX_VL = 32,
    parameter int VLW    = $clog2(MAX_VL + 1),
    parameter int EW     = $clog2(MAX_VL)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [VLW-1:0] vlen_in,
    input  logic           indexed,
    input  logic           idx_valid,
    input  logic           out_ready,
    output logic           cmd_ready,
    output logic           accept,
    output logic           issue,
    output logic [EW-1:0]  issue_elem,
    output logic           idx_ready,
    output logic           out_valid,
    output logic           out_last,
    output logic           done
);
    logic           busy;
    logic [VLW-1:0] vl_r;
    logic [VLW-1:0] issued;
    logic [VLW-1:0] vl_c;
    logic           slot_free;
    logic           more;
    logic           final_hs;

    assign vl_c       = (vlen_in > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vlen_in;
    assign cmd_ready  = !busy;
    assign accept     = start && !busy;
    assign slot_free  = !out_valid || out_ready;
    assign more       = issued < vl_r;
    assign idx_ready  = busy && indexed && more && slot_free;
    assign issue      = busy && more && slot_free && (!indexed || idx_valid);
    assign issue_elem = issued[EW-1:0];
    assign final_hs   = out_valid && out_ready && out_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            vl_r      <= '0;
            issued    <= '0;
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy   <= (vl_c != '0);
                vl_r   <= vl_c;
                issued <= '0;
                done   <= (vl_c == '0);
            end else begin
                if (issue) begin
                    out_valid <= 1'b1;
                    out_last  <= (issued == vl_r - VLW'(1));
                    issued    <= issued + VLW'(1);
                end else if (out_ready) begin
                    out_valid <= 1'b0;
                end
                if (final_hs) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R8: completion is a single-cycle pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> !done);

    // R8: completion follows the final handshake by one edge
    p_done_after_last_r8: assert property (@(posedge clk) disable iff (rst)
        final_hs |=> done && cmd_ready);

    // R9: empty command completes at once and emits nothing
    p_zero_len_r9: assert property (@(posedge clk) disable iff (rst)
        accept && vl_c == '0 |=> done && !out_valid);

    // R7: never more issues than the clamped count
    p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
        issued <= VLW'(MAX_VL));

endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
    import vag_pkg::*;
#(
    parameter int AW         = 32,
    parameter int IW         = 16,
    parameter int MAX_VL     = 32,
    parameter int NBANK      = 8,
    parameter int WORD_BYTES = 8,
    localparam int VLW       = $clog2(MAX_VL + 1),
    localparam int EW        = $clog2(MAX_VL),
    localparam int BW        = $clog2(NBANK)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_start,
    output logic           cmd_ready,
    input  logic [AW-1:0]  cmd_base,
    input  logic [1:0]     cmd_mode,
    input  logic [AW-1:0]  cmd_stride,
    input  logic [1:0]     cmd_ewidth,
    input  logic [VLW-1:0] cmd_vlen,
    input  logic           idx_valid,
    output logic           idx_ready,
    input  logic [IW-1:0]  idx_data,
    output logic           addr_valid,
    input  logic           addr_ready,
    output logic [AW-1:0]  addr_out,
    output logic [EW-1:0]  addr_elem,
    output logic [BW-1:0]  addr_bank,
    output logic           done
);
    acfg_t          cfg_r;
    logic [AW-1:0]  base_r;
    logic [AW-1:0]  stride_r;
    logic [AW-1:0]  cur_r;
    logic [AW-1:0]  step;
    logic [AW-1:0]  gather_addr;
    logic [AW-1:0]  out_addr;
    logic [EW-1:0]  out_elem;
    logic           accept;
    logic           issue;
    logic [EW-1:0]  issue_elem;
    logic           out_last;

    vag_seq #(.MAX_VL(MAX_VL), .VLW(VLW), .EW(EW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (cmd_start),
        .vlen_in    (cmd_vlen),
        .indexed    (is_indexed(cfg_r.mode)),
        .idx_valid  (idx_valid),
        .out_ready  (addr_ready),
        .cmd_ready  (cmd_ready),
        .accept     (accept),
        .issue      (issue),
        .issue_elem (issue_elem),
        .idx_ready  (idx_ready),
        .out_valid  (addr_valid),
        .out_last   (out_last),
        .done       (done)
    );

    vag_step #(.AW(AW)) u_step (
        .cfg    (cfg_r),
        .stride (stride_r),
        .step   (step)
    );

    vag_index_scale #(.AW(AW), .IW(IW)) u_scale (
        .base  (base_r),
        .index (idx_data),
        .width (cfg_r.width),
        .addr  (gather_addr)
    );

    vag_bank_sel #(.AW(AW), .NBANK(NBANK), .WORD_BYTES(WORD_BYTES)) u_bank (
        .addr (out_addr),
        .bank (addr_bank)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_r    <= '{mode: AM_UNIT, width: EW_8};
            base_r   <= '0;
            stride_r <= '0;
            cur_r    <= '0;
            out_addr <= '0;
            out_elem <= '0;
        end else if (accept) begin
            cfg_r    <= '{mode: amode_e'(cmd_mode), width: ewidth_e'(cmd_ewidth)};
            base_r   <= cmd_base;
            stride_r <= cmd_stride;
            cur_r    <= cmd_base;
        end else if (issue) begin
            out_addr <= is_indexed(cfg_r.mode) ? gather_addr : cur_r;
            out_elem <= issue_elem;
            cur_r    <= cur_r + step;
        end
    end

    assign addr_out  = out_addr;
    assign addr_elem = out_elem;

    // R10: a stalled address is held unchanged
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        addr_valid && !addr_ready |=>
            addr_valid && $stable(addr_out) && $stable(addr_elem));

    // R4: no index is requested outside indexed mode
    p_idx_mode_r4: assert property (@(posedge clk) disable iff (rst)
        idx_ready |-> cfg_r.mode == AM_INDEX && !cmd_ready);

endmodule

// File: tb/test_vec_addr_gen.sv
`timescale 1ns/1ps
module test_vec_addr_gen;
    localparam int AW = 32;
    localparam int IW = 16;
    localparam int VLW = 6;
    localparam int EW = 5;
    localparam int BW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_start = 1'b0;
    logic cmd_ready;
    logic [AW-1:0] cmd_base = '0;
    logic [1:0] cmd_mode = '0;
    logic [AW-1:0] cmd_stride = '0;
    logic [1:0] cmd_ewidth = '0;
    logic [VLW-1:0] cmd_vlen = '0;
    logic idx_valid = 1'b0;
    logic idx_ready;
    logic [IW-1:0] idx_data = '0;
    logic addr_valid;
    logic addr_ready = 1'b1;
    logic [AW-1:0] addr_out;
    logic [EW-1:0] addr_elem;
    logic [BW-1:0] addr_bank;
    logic done;

    always #10 clk = ~clk;

    vec_addr_gen i_vec_addr_gen (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_ready(cmd_ready),
        .cmd_base(cmd_base), .cmd_mode(cmd_mode), .cmd_stride(cmd_stride),
        .cmd_ewidth(cmd_ewidth), .cmd_vlen(cmd_vlen), .idx_valid(idx_valid),
        .idx_ready(idx_ready), .idx_data(idx_data), .addr_valid(addr_valid),
        .addr_ready(addr_ready), .addr_out(addr_out), .addr_elem(addr_elem),
        .addr_bank(addr_bank), .done(done)
    );

    typedef struct {
        logic [AW-1:0] a;
        int            e;
        bit            last;
        bit            ix;
        string         req;
    } exp_t;

    exp_t sb[$];
    int n_checks = 0;
    int n_fail = 0;
    int rdy_mode = 0;
    int cyc = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // ready pattern driver
    initial begin
        forever begin
            @(posedge clk); #1;
            cyc++;
            case (rdy_mode)
                0: addr_ready = 1'b1;
                1: addr_ready = ~addr_ready;
                default: addr_ready = (cyc % 3) != 0;
            endcase
        end
    end

    // monitor / scoreboard
    bit due_here = 0;
    bit held = 0;
    logic [AW-1:0] held_a;
    logic [EW-1:0] held_e;
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                bit due_next;
                if (done || due_here)
                    chk(done == due_here, "R8", "done pulse timing", done, due_here);
                due_next = 0;
                if (cmd_start && cmd_ready && cmd_vlen == 0) due_next = 1;
                if (held)
                    chk(addr_valid && addr_out == held_a && addr_elem == held_e,
                        "R10", "stalled address held", addr_out, held_a);
                held = addr_valid && !addr_ready;
                held_a = addr_out;
                held_e = addr_elem;
                if (addr_valid && addr_ready) begin
                    if (sb.size() == 0) begin
                        chk(0, "R7", "address beyond element count", addr_out, 0);
                    end else begin
                        exp_t x;
                        x = sb.pop_front();
                        chk(addr_out == x.a, x.req, "address", addr_out, x.a);
                        chk(int'(addr_elem) == x.e, "R6", "element tag", addr_elem, x.e);
                        chk(addr_bank == x.a[5:3], "R5", "bank", addr_bank, x.a[5:3]);
                        if (!x.ix) chk(!idx_ready, "R4", "idx_ready outside indexed", idx_ready, 0);
                        if (x.last) due_next = 1;
                    end
                end
                due_here = due_next;
            end
        end
    end

    function automatic logic [IW-1:0] idx_of(input int k, input int seed);
        return IW'((k * 1237 + seed * 311 + (k * k * 7)) & 16'hffff);
    endfunction

    task automatic run_cmd(input logic [1:0] mode, input logic [1:0] ew,
                           input logic [AW-1:0] base, input logic [AW-1:0] stride,
                           input int vlen, input int seed, input int gap);
        int n;
        n = (vlen > 32) ? 32 : vlen;
        for (int k = 0; k < n; k++) begin
            exp_t x;
            x.e = k;
            x.last = (k == n - 1);
            x.ix = (mode == 2);
            if (mode == 2) begin
                x.a = base + (AW'(idx_of(k, seed)) << ew);
                x.req = "R4";
            end else if (mode == 1) begin
                x.a = base + AW'(k) * stride;
                x.req = "R3";
            end else begin
                x.a = base + (AW'(k) << ew);
                x.req = "R2";
            end
            sb.push_back(x);
        end
        @(posedge clk); #1;
        cmd_start = 1; cmd_mode = mode; cmd_ewidth = ew; cmd_base = base;
        cmd_stride = stride; cmd_vlen = VLW'(vlen);
        @(posedge clk); #1;
        cmd_start = 0;
        @(negedge clk);
        if (n > 0) chk(!cmd_ready, "R1", "busy after accept", cmd_ready, 0);
        else chk(cmd_ready && !addr_valid, "R9", "idle after empty command", cmd_ready, 1);
        if (mode == 2) begin
            for (int k = 0; k < n; k++) begin
                for (int g = 0; g < ((k % 3 == 1) ? gap : 0); g++) begin
                    @(posedge clk); #1; idx_valid = 0;
                end
                @(posedge clk); #1;
                idx_valid = 1; idx_data = idx_of(k, seed);
                forever begin
                    bit got;
                    @(negedge clk);
                    got = idx_ready;
                    @(posedge clk); #1;
                    if (got) break;
                end
                idx_valid = 0;
            end
        end
        forever begin
            @(negedge clk);
            if (cmd_ready) break;
        end
        @(negedge clk);
        chk(sb.size() == 0, "R7", "all addresses emitted", sb.size(), 0);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk(!addr_valid && !idx_ready && !done && cmd_ready, "R11", "reset outputs",
            {addr_valid, idx_ready, done, cmd_ready}, 4'b0001);
        @(posedge clk); #1; rst = 0;

        rdy_mode = 0;
        run_cmd(2'd0, 2'd0, 32'h0000_1000, 0, 8, 0, 0);       // R2 bytes
        run_cmd(2'd0, 2'd3, 32'h0000_2038, 0, 32, 0, 0);      // R2 doublewords, full length
        rdy_mode = 1;
        run_cmd(2'd0, 2'd1, 32'h0000_0106, 0, 5, 0, 0);       // R2 halfwords, R10 stalls
        run_cmd(2'd3, 2'd2, 32'h0000_0400, 0, 4, 0, 0);       // R2 reserved mode
        rdy_mode = 0;
        run_cmd(2'd1, 2'd2, 32'h0000_4000, 32'd24, 10, 0, 0); // R3 positive
        run_cmd(2'd1, 2'd0, 32'h0000_0100, -32'sd40, 7, 0, 0);// R3 negative
        rdy_mode = 2;
        run_cmd(2'd1, 2'd3, 32'hFFFF_FFF0, 32'd72, 9, 0, 0);  // R3 wrap, stalls
        run_cmd(2'd2, 2'd3, 32'h0001_0000, 0, 12, 3, 2);      // R4 gather with gaps
        rdy_mode = 0;
        run_cmd(2'd2, 2'd0, 32'h0002_0000, 0, 32, 5, 0);      // R4 bytes
        run_cmd(2'd2, 2'd1, 32'h0003_0002, 0, 6, 9, 3);       // R4 halfwords
        run_cmd(2'd0, 2'd2, 32'h0000_5000, 0, 0, 0, 0);       // R9 empty
        run_cmd(2'd0, 2'd2, 32'h0000_6000, 0, 45, 0, 0);      // R7 clamp to 32
        rdy_mode = 1;
        run_cmd(2'd1, 2'd1, 32'h0000_7000, 32'd8, 1, 0, 0);   // R8 single element
        run_cmd(2'd2, 2'd2, 32'h0000_8000, 0, 0, 1, 0);       // R9 empty indexed
        run_cmd(2'd0, 2'd3, 32'h0000_9000, 0, 3, 0, 0);       // R1 follow-on command
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule